// File: doc/BRIEF.md
# Memory Presence Descriptor Encoder

This block turns a memory size, given in megabytes, into a 64-byte presence descriptor that boot logic or a management controller reads to learn how much memory is fitted and how it is arranged. The descriptor lives in an internal byte store that comes out of reset holding a fixed template. A run patches three bytes: the memory type code, the bank count and the density map. It then rewrites the last byte with a checksum of the rest.

A run starts with a one-cycle `start` pulse. The size is split greedily into at most three power-of-two banks, with the bank exponent capped. The bank exponents are gathered into a density bitmap. A lone bank is halved into two where the bitmap allows it. High density bits are folded into the low byte, and the fold also picks the type code. The engine writes the three fields and then sums bytes 0 to 62 one byte per clock. It ends the run with a single-cycle `done` pulse. A flag reports when part of the size could not be expressed. The descriptor can be read at any time through a byte read port with one cycle of latency.

Top module: `mpd_encoder`

## Requirements
- R1: After reset `busy`, `done` and `leftover` are 0, and descriptor byte i holds the template value (37*i + 11) mod 256 for every i in 0..63.
- R2: Starting from remaining = size, banks = 0 and density = 0, each decomposition step runs only while remaining >= 4 and banks <= 2. A step takes e = min(floor(log2(remaining)), 14), adds one bank, sets density bit e-2 and subtracts 2^e from remaining.
- R3: When the decomposition leaves exactly one bank and a density above 1, the bank count becomes 2 and the density is shifted right by one bit.
- R4: If any density bit from 15 down to 8 is set, the density becomes (density & 0xE0) | ((density >> 8) & 0x1F) and the type code is 0x08. Otherwise the type code is 0x08 when density bits 4..0 are all zero, and 0x04 when any of them is set.
- R5: After a run, byte 2 holds the type code, byte 5 holds the bank count (0 to 3) and byte 31 holds the low 8 bits of the final density.
- R6: After a run, byte 63 equals the sum modulo 256 of bytes 0 through 62.
- R7: `leftover` is 1 exactly when the remaining size is non-zero once decomposition stops. It is valid when `done` pulses and holds until the next run.
- R8: A run with k decomposition steps raises `done` for exactly one cycle, k + 69 clock edges after the edge that accepted `start`. `busy` is high from the accepting edge until `done` rises, and `done` is never high together with `busy`.
- R9: A `start` pulse that arrives while `busy` is high is ignored: the size and timing of the run in progress are unaffected.
- R10: `rd_data` presents the descriptor byte addressed by `rd_addr` one clock later. Bytes other than 2, 5, 31 and 63 keep their template values across runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the current size (ignored while busy) |
| size_mb | input | 16 | Memory size in megabytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the descriptor is complete |
| leftover | output | 1 | Part of the size could not be represented |
| rd_addr | input | 6 | Descriptor byte address |
| rd_data | output | 8 | Descriptor byte, one cycle after the address |

## Verification
The hardest conditions to reach from the ports are the capped exponent paired with leftover capacity, and the high-density fold that moves bits 8 to 12 into the low byte. Only large sizes reach them, so the stimulus includes sizes of 1 GB and above, and the 16-bit maximum, which exhausts all three banks at the cap. A lone-bank size such as 256 lands on the split path and gives a type code chosen by an empty low field. Repeated `start` pulses are fired both during decomposition and during the checksum pass, to show that they are dropped.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  // Byte positions that a descriptor reader decodes
  localparam int unsigned POS_TYPE  = 2;
  localparam int unsigned POS_BANKS = 5;
  localparam int unsigned POS_DENS  = 31;

  localparam logic [7:0] TYPE_NARROW = 8'h04;
  localparam logic [7:0] TYPE_WIDE   = 8'h08;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECOMP, ST_FOLD, ST_WTYPE,
    ST_WBANK, ST_WDENS, ST_SUM, ST_WSUM
  } mpd_state_e;

  // Preload template for the descriptor store
  function automatic logic [7:0] tpl_byte(input int unsigned idx);
    return 8'((idx * 37 + 11) % 256);
  endfunction

endpackage

// File: rtl/mpd_lod.sv
module mpd_lod #(
  parameter int unsigned W  = 16,
  localparam int unsigned LW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  output logic [LW-1:0] msb
);
  always_comb begin
    msb = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) msb = LW'(i);
    end
  end

  // R2: the detected position is the highest set bit
  always_comb begin
    if (val != '0) begin
      lod_pos_chk: assert ((val >> msb) == W'(1));
    end
  end
endmodule

// File: rtl/mpd_bank_step.sv
module mpd_bank_step #(
  parameter int unsigned SIZE_W    = 16,
  parameter int unsigned MAX_EXP   = 14,
  parameter int unsigned MAX_BANKS = 3,
  parameter int unsigned DENS_W    = 16,
  localparam int unsigned LW = $clog2(SIZE_W),
  localparam int unsigned BW = $clog2(MAX_BANKS + 1)
) (
  input  logic [SIZE_W-1:0] rem,
  input  logic [BW-1:0]     banks,
  output logic              go,
  output logic [SIZE_W-1:0] rem_next,
  output logic [DENS_W-1:0] dens_bit
);
  logic [LW-1:0] msb;
  logic [LW-1:0] expo;

  mpd_lod #(.W(SIZE_W)) u_lod (.val(rem), .msb(msb));

  always_comb begin
    expo     = (msb > LW'(MAX_EXP)) ? LW'(MAX_EXP) : msb;
    go       = (rem >= SIZE_W'(4)) && (banks < BW'(MAX_BANKS));
    rem_next = rem - (SIZE_W'(1) << expo);
    dens_bit = DENS_W'(1) << (expo - LW'(2));
  end
endmodule

// File: rtl/mpd_store.sv
module mpd_store #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] cs_addr,
  output logic [7:0]    cs_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= mpd_pkg::tpl_byte(i);
      rd_data <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rd_data <= mem[rd_addr];
    end
  end

  assign cs_data = mem[cs_addr];
endmodule

// File: rtl/mpd_encoder.sv
module mpd_encoder #(
  parameter int unsigned SIZE_W    = 16,
  parameter int unsigned MAX_EXP   = 14,
  parameter int unsigned MAX_BANKS = 3,
  parameter int unsigned DENS_W    = 16,
  parameter int unsigned DEPTH     = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned BW = $clog2(MAX_BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SIZE_W-1:0] size_mb,
  output logic              busy,
  output logic              done,
  output logic              leftover,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data
);
  import mpd_pkg::*;

  mpd_state_e        state_q;
  logic [SIZE_W-1:0] rem_q;
  logic [BW-1:0]     banks_q;
  logic [DENS_W-1:0] dens_q;
  logic [7:0]        dens8_q, type_q, sum_q;
  logic [AW-1:0]     idx_q;
  logic              done_q, left_q;

  logic              step_go;
  logic [SIZE_W-1:0] step_rem;
  logic [DENS_W-1:0] step_bit;

  mpd_bank_step #(
    .SIZE_W(SIZE_W), .MAX_EXP(MAX_EXP),
    .MAX_BANKS(MAX_BANKS), .DENS_W(DENS_W)
  ) u_step (
    .rem(rem_q), .banks(banks_q),
    .go(step_go), .rem_next(step_rem), .dens_bit(step_bit)
  );

  // Split of a lone bank, then fold of high density bits
  logic              split, hi;
  logic [BW-1:0]     banks_f;
  logic [DENS_W-1:0] dens_s, dens_f;
  logic [7:0]        type_f;

  always_comb begin
    split   = (banks_q == BW'(1)) && (dens_q > DENS_W'(1));
    banks_f = split ? BW'(2) : banks_q;
    dens_s  = split ? (dens_q >> 1) : dens_q;
    hi      = |dens_s[DENS_W-1:8];
    dens_f  = hi ? ((dens_s & DENS_W'('hE0)) | ((dens_s >> 8) & DENS_W'('h1F)))
                 : dens_s;
    if (hi)                     type_f = TYPE_WIDE;
    else if (dens_s[4:0] == '0) type_f = TYPE_WIDE;
    else                        type_f = TYPE_NARROW;
  end

  // Store write and checksum read selection
  logic          we;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata, cs_data;

  always_comb begin
    we    = 1'b0;
    waddr = '0;
    wdata = '0;
    unique case (state_q)
      ST_WTYPE: begin we = 1'b1; waddr = AW'(POS_TYPE);  wdata = type_q;  end
      ST_WBANK: begin we = 1'b1; waddr = AW'(POS_BANKS); wdata = 8'(banks_q); end
      ST_WDENS: begin we = 1'b1; waddr = AW'(POS_DENS);  wdata = dens8_q; end
      ST_WSUM:  begin we = 1'b1; waddr = AW'(DEPTH - 1); wdata = sum_q;   end
      default: ;
    endcase
  end

  mpd_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .cs_addr(idx_q), .cs_data(cs_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      banks_q <= '0;
      dens_q  <= '0;
      dens8_q <= '0;
      type_q  <= '0;
      sum_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      left_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          rem_q   <= size_mb;
          banks_q <= '0;
          dens_q  <= '0;
          state_q <= ST_DECOMP;
        end
        ST_DECOMP: if (step_go) begin
          rem_q   <= step_rem;
          banks_q <= banks_q + BW'(1);
          dens_q  <= dens_q | step_bit;
        end else begin
          state_q <= ST_FOLD;
        end
        ST_FOLD: begin
          banks_q <= banks_f;
          dens8_q <= dens_f[7:0];
          type_q  <= type_f;
          left_q  <= (rem_q != '0);
          state_q <= ST_WTYPE;
        end
        ST_WTYPE: state_q <= ST_WBANK;
        ST_WBANK: state_q <= ST_WDENS;
        ST_WDENS: begin
          idx_q   <= '0;
          sum_q   <= '0;
          state_q <= ST_SUM;
        end
        ST_SUM: begin
          sum_q <= sum_q + cs_data;
          idx_q <= idx_q + AW'(1);
          if (idx_q == AW'(DEPTH - 2)) state_q <= ST_WSUM;
        end
        ST_WSUM: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign leftover = left_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state_q != ST_WSUM) |=> busy);
  // R2
  rem_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECOMP) |=> (rem_q <= $past(rem_q)));
  // R3
  split_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FOLD) |=> (banks_q != BW'(1) || dens8_q <= 8'd1));
  // R4
  type_code_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FOLD) |=> (type_q == TYPE_WIDE || type_q == TYPE_NARROW));
endmodule

// File: tb/mpd_encoder_bench.sv
module mpd_encoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] size_mb = '0;
  logic [5:0]  rd_addr = '0;
  logic        busy, done, leftover;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] exp_mem [64];
  int exp_k = 0;
  bit exp_left = 1'b0;

  int  cnt = 0;
  bit  done_e = 1'b0;

  always #2 clk = ~clk;

  mpd_encoder u_mpd_encoder (
    .clk(clk), .rst(rst), .start(start), .size_mb(size_mb),
    .busy(busy), .done(done), .leftover(leftover),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Behavioural reference of one run, applied to the expected descriptor
  task automatic compute_ref(input int size);
    int rem = size;
    int banks = 0;
    int dens = 0;
    int typ;
    int sum = 0;
    exp_k = 0;
    while (rem >= 4 && banks <= 2) begin
      int e = 0;
      int t = rem;
      while (t > 1) begin t = t / 2; e++; end
      if (e > 14) e = 14;
      banks++;
      dens = dens | (1 << (e - 2));
      rem = rem - (1 << e);
      exp_k++;
    end
    if (banks == 1 && dens > 1) begin banks = 2; dens = dens >> 1; end
    if ((dens & 'hFF00) != 0) begin
      dens = (dens & 'hE0) | ((dens >> 8) & 'h1F);
      typ = 8;
    end else if ((dens & 'h1F) == 0) typ = 8;
    else typ = 4;
    exp_left = (rem != 0);
    exp_mem[2]  = 8'(typ);
    exp_mem[5]  = 8'(banks);
    exp_mem[31] = 8'(dens);
    for (int i = 0; i < 63; i++) sum = sum + int'(exp_mem[i]);
    exp_mem[63] = 8'(sum);
  endtask

  // Cycle model of busy/done
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      cnt = 0;
      done_e = 1'b0;
    end else if (cnt > 0) begin
      done_e = (cnt == 1);
      cnt--;
    end else begin
      done_e = 1'b0;
      if (start) cnt = exp_k + 69;
    end
  end

  // Compared every clock: R8 timing, R9 ignored starts
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == (cnt != 0), "R8/R9 busy", int'(busy), int'(cnt != 0));
      chk(done == done_e, "R8/R9 done", int'(done), int'(done_e));
    end
  end

  task automatic read_all(input string tag);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk) rd_addr = 6'(i);
      @(negedge clk);
      chk(rd_data == exp_mem[i], tag, int'(rd_data), int'(exp_mem[i]));
    end
  endtask

  task automatic wait_done(input int k);
    int cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == k + 69, "R8 latency", cyc, k + 69);
    chk(leftover == exp_left, "R7 leftover", int'(leftover), int'(exp_left));
  endtask

  task automatic run(input int size);
    int k;
    compute_ref(size);
    k = exp_k;
    @(negedge clk) begin size_mb = 16'(size); start = 1'b1; end
    @(negedge clk) start = 1'b0;
    wait_done(k);
    read_all("R2/R3/R4/R5/R6/R10 descriptor");
    chk(leftover == exp_left, "R7 leftover held", int'(leftover), int'(exp_left));
  endtask

  task automatic run_poked(input int size, input int other, input int gap);
    int k;
    compute_ref(size);
    k = exp_k;
    @(negedge clk) begin size_mb = 16'(size); start = 1'b1; end
    @(negedge clk) start = 1'b0;
    repeat (gap) @(negedge clk);
    size_mb = 16'(other);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(k - gap - 1);
    read_all("R9 descriptor after ignored start");
  endtask

  initial begin
    int sizes[13] = '{0, 3, 4, 7, 8, 100, 128, 256, 1000, 1536, 12000, 40000, 65535};
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'((i * 37 + 11) % 256);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(leftover == 1'b0, "R1 leftover", int'(leftover), 0);
    read_all("R1 template");
    foreach (sizes[i]) run(sizes[i]);
    run_poked(1536, 8, 1);
    run_poked(65535, 4, 40);
    run(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL R8 watchdog actual=%0d expected=<150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule